// File: doc/BRIEF.md
# Programmable Skew Clock Output Controller

This block drives eight clock outputs, arranged as four banks of two, from a fast tick clock. One tick is the skew time unit, and the nominal output period is a whole number of ticks chosen by a frequency-select code. Each bank reads its own two-digit three-level control word. It then produces one of four outputs: a copy of the reference phase delayed or advanced by a multiple of the time unit, a divided copy of the reference phase, or an inverted copy of it.

A registered output stop lets all banks except the feedback bank (bank 2) halt at a rest level that depends on the polarity select. A three-level test code turns the stop into a per-bank disable that acts only on banks coded LL. Three-level inputs arrive already encoded as two-bit codes: `00` = LOW, `01` = MID, `10` = HIGH, and `11` = open, which behaves as MID.

Top module: `skew_clock_ctrl`

## Requirements
- R1: The frequency-select code LOW, MID or HIGH sets the output period to 32, 16 or 8 ticks. The tick counter runs from 0 to period−1 and restarts at 0 (the phase origin). A zero-skew output with positive polarity is high for ticks 0 to period/2−1. Each output is registered: the value seen after a clock edge belongs to the tick counted before that edge. The frequency code changes only while reset is held.
- R2: For banks 1 and 2, the control word {F1,F0} picks a skew. The index 3·F1+F0 (L=0, M=1, H=2) gives skew (index−4) time units, from −4 to +4. A skew of +k delays the output by k ticks. A skew of −k delays it by period−k ticks.
- R3: Bank 3 uses skew 2·(index−4) time units for indices 1 to 7. LL (index 0) gives an output divided by 2. HH (index 8) gives an output divided by 4. Divided outputs change only at the phase origin, and both are high during period 0 after reset, so their rising edges coincide.
- R4: Bank 4 uses the same skews and the same divide-by-2 on LL as bank 3. On HH it outputs the complement of the zero-skew output.
- R5: The code `11` on either digit of a control word acts exactly as MID, so an open word selects zero skew.
- R6: With negative polarity (pos_edge = 0), every skewed and inverted output is the complement of its positive-polarity waveform, so zero-skew outputs fall at the origin. Divided outputs are unchanged. Polarity changes only while no bank is stopped.
- R7: stop_en is registered once before it is used. While the registered stop is high and the test code is not MID, banks 1, 3 and 4 stop and bank 2 keeps running. The rest level is LOW for positive polarity and HIGH for negative polarity. For bank 4 in inverted mode these levels are swapped.
- R8: A bank enters or leaves the stopped state only at a cycle where its running waveform moves into the rest level. No output pulse is ever shortened.
- R9: While the test code is MID and the registered stop is high, only banks whose control word is LL are stopped, bank 2 included. All other banks keep running with their programmed mode.
- R10: The two outputs of a bank are always equal.
- R11: A synchronous reset drives all outputs low and clears the tick counter, the period counter used by the dividers, the registered stop and every stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one cycle is one skew time unit |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | 2 | Three-level frequency code selecting the period of 32/16/8 ticks |
| pos_edge | input | 1 | 1: align to the rising reference edge; 0: align to the falling edge |
| stop_en | input | 1 | Synchronous output stop request |
| test_sel | input | 2 | Three-level test code; MID turns stop into the per-bank LL disable |
| bank_ctrl | input | 16 | Four control words; bank n uses bits [4n−1:4n−4], F1 in the upper pair |
| out_a | output | 4 | First output of each bank (bit n−1 is bank n) |
| out_b | output | 4 | Second output of each bank |

## Verification
Every output is due one clock after the tick that defines it. A stop request reaches the stop decision one cycle after it is sampled, and it shows at the outputs only at the next cycle where the bank's waveform moves into its rest level. The bench model advances on each rising edge, using the inputs the bench set at the previous falling edge, and compares all eight outputs at the next falling edge. Each result is therefore checked exactly in the cycle it becomes due. Stimulus changes only at falling edges, and the frequency code changes only under reset.

// File: rtl/skc_pkg.sv
package skc_pkg;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  typedef enum logic [1:0] {
    BK_FINE,
    BK_WIDE_DIV4,
    BK_WIDE_INV
  } bank_kind_e;

  typedef enum logic [1:0] {
    MD_SKEW,
    MD_DIV2,
    MD_DIV4,
    MD_INV
  } bank_mode_e;

  // Open code (11) behaves as the middle level.
  function automatic logic [1:0] lvl_norm(input logic [1:0] c);
    return (c == 2'b11) ? LVL_MID : c;
  endfunction

endpackage

// File: rtl/skc_timebase.sv
module skc_timebase
  import skc_pkg::*;
#(
  parameter int P_LOW  = 32,
  parameter int P_MID  = 16,
  parameter int P_HIGH = 8,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       freq_sel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W:0]   period,
  output logic [1:0]       pc
);

  localparam int PW = CNT_W + 1;

  always_comb begin
    unique case (lvl_norm(freq_sel))
      LVL_LOW:  period = PW'(P_LOW);
      LVL_HIGH: period = PW'(P_HIGH);
      default:  period = PW'(P_MID);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pc  <= '0;
    end else if ({1'b0, cnt} >= period - 1'b1) begin
      cnt <= '0;
      pc  <= pc + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} < period));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc != $past(pc)) |-> ($past(cnt) == CNT_W'($past(period) - 1'b1)));

endmodule

// File: rtl/skc_bank_gen.sv
module skc_bank_gen
  import skc_pkg::*;
#(
  parameter bank_kind_e KIND  = BK_FINE,
  parameter int         CNT_W = 5
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W:0]   period,
  input  logic [1:0]       pc,
  input  logic [3:0]       ctrl,
  input  logic             pos_edge,
  output logic             raw_n,
  output logic             rest_lvl,
  output logic             is_ll
);

  logic [3:0] idx;
  bank_mode_e mode;
  int         step;
  int         dly;
  int         diff;
  logic       ph_pos;
  logic       ph;

  always_comb begin
    idx  = 4'(3 * int'(lvl_norm(ctrl[3:2])) + int'(lvl_norm(ctrl[1:0])));
    mode = MD_SKEW;
    step = int'(idx) - 4;
    if (KIND != BK_FINE) begin
      step = 2 * step;
      if (idx == 4'd0) begin
        mode = MD_DIV2;
      end else if (idx == 4'd8) begin
        mode = (KIND == BK_WIDE_DIV4) ? MD_DIV4 : MD_INV;
      end
    end
    if (mode != MD_SKEW) step = 0;

    // Negative skew is a long delay against the wrapping counter.
    dly  = (step < 0) ? int'(period) + step : step;
    diff = int'(cnt) - dly;
    if (diff < 0) diff = diff + int'(period);
    ph_pos = (diff < (int'(period) / 2));
    ph     = pos_edge ? ph_pos : !ph_pos;

    unique case (mode)
      MD_DIV2: raw_n = !pc[0];
      MD_DIV4: raw_n = !pc[1];
      MD_INV:  raw_n = !ph;
      default: raw_n = ph;
    endcase

    rest_lvl = (mode == MD_INV) ? pos_edge : !pos_edge;
    is_ll    = (idx == 4'd0);
  end

endmodule

// File: rtl/skc_stop_gate.sv
module skc_stop_gate (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_n,
  input  logic       rest_lvl,
  input  logic       stop_req,
  output logic [1:0] q
);

  logic raw_q;
  logic stopped_q;
  logic stopped_n;
  logic into_rest;
  logic out_n;

  always_comb begin
    into_rest = (raw_n == rest_lvl) && (raw_q != rest_lvl);
    stopped_n = into_rest ? stop_req : stopped_q;
    out_n     = stopped_n ? rest_lvl : raw_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q     <= 1'b0;
      stopped_q <= 1'b0;
      q         <= '0;
    end else begin
      raw_q     <= raw_n;
      stopped_q <= stopped_n;
      q         <= {2{out_n}};
    end
  end

  // R8
  no_runt_chk: assert property (@(posedge clk) disable iff (rst)
    (q[0] != $past(q[0])) |-> (raw_q != $past(raw_q)));

  // R7
  stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stopped_q) |-> $past(stop_req));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stopped_q) |-> !$past(stop_req));

endmodule

// File: rtl/skew_clock_ctrl.sv
module skew_clock_ctrl
  import skc_pkg::*;
#(
  parameter int P_LOW     = 32,
  parameter int P_MID     = 16,
  parameter int P_HIGH    = 8,
  parameter int NUM_BANKS = 4,
  parameter int FB_BANK   = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             freq_sel,
  input  logic                   pos_edge,
  input  logic                   stop_en,
  input  logic [1:0]             test_sel,
  input  logic [4*NUM_BANKS-1:0] bank_ctrl,
  output logic [NUM_BANKS-1:0]   out_a,
  output logic [NUM_BANKS-1:0]   out_b
);

  localparam int CNT_W = $clog2(P_LOW);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   period;
  logic [1:0]       pc;
  logic             stop_r;
  logic             test_mid;

  skc_timebase #(
    .P_LOW (P_LOW),
    .P_MID (P_MID),
    .P_HIGH(P_HIGH),
    .CNT_W (CNT_W)
  ) u_timebase (
    .clk     (clk),
    .rst     (rst),
    .freq_sel(freq_sel),
    .cnt     (cnt),
    .period  (period),
    .pc      (pc)
  );

  always_ff @(posedge clk) begin
    if (rst) stop_r <= 1'b0;
    else     stop_r <= stop_en;
  end

  assign test_mid = (lvl_norm(test_sel) == LVL_MID);

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    localparam bank_kind_e K = (gi == NUM_BANKS - 1) ? BK_WIDE_INV :
                               (gi == NUM_BANKS - 2) ? BK_WIDE_DIV4 : BK_FINE;
    logic       raw_n;
    logic       rest_lvl;
    logic       is_ll;
    logic       req;
    logic [1:0] q;

    skc_bank_gen #(
      .KIND (K),
      .CNT_W(CNT_W)
    ) u_gen (
      .cnt     (cnt),
      .period  (period),
      .pc      (pc),
      .ctrl    (bank_ctrl[4*gi +: 4]),
      .pos_edge(pos_edge),
      .raw_n   (raw_n),
      .rest_lvl(rest_lvl),
      .is_ll   (is_ll)
    );

    assign req = stop_r && (test_mid ? is_ll : (gi != FB_BANK));

    skc_stop_gate u_gate (
      .clk     (clk),
      .rst     (rst),
      .raw_n   (raw_n),
      .rest_lvl(rest_lvl),
      .stop_req(req),
      .q       (q)
    );

    assign out_a[gi] = q[0];
    assign out_b[gi] = q[1];
  end

  // R10
  pair_match_chk: assert property (@(posedge clk) disable iff (rst)
    (out_a == out_b));

endmodule

// File: tb/test_skew_clock_ctrl.sv
module test_skew_clock_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  freq_sel;
  logic        pos_edge;
  logic        stop_en;
  logic [1:0]  test_sel;
  logic [15:0] bank_ctrl;
  logic [3:0]  out_a;
  logic [3:0]  out_b;

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  string tag = "R11";

  // behavioural reference state
  int m_cnt, m_pc;
  bit m_stop;
  bit m_raw[4];
  bit m_stp[4];
  bit m_out[4];

  skew_clock_ctrl i_skew_clock_ctrl (
    .clk      (clk),
    .rst      (rst),
    .freq_sel (freq_sel),
    .pos_edge (pos_edge),
    .stop_en  (stop_en),
    .test_sel (test_sel),
    .bank_ctrl(bank_ctrl),
    .out_a    (out_a),
    .out_b    (out_b)
  );

  always #5 clk = ~clk;

  function automatic int lv(logic [1:0] c);
    return (c == 2'b11) ? 1 : int'(c);
  endfunction

  function automatic int per_of(logic [1:0] f);
    case (lv(f))
      0: return 32;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [1:0] enc(int v);
    return (v == 0) ? 2'b00 : (v == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [3:0] word(int sel);
    return {enc(sel / 3), enc(sel % 3)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_pc = 0; m_stop = 0;
      for (int b = 0; b < 4; b++) begin
        m_raw[b] = 0; m_stp[b] = 0; m_out[b] = 0;
      end
    end else begin
      int p;
      bit tmid;
      p = per_of(freq_sel);
      tmid = (lv(test_sel) == 1);
      for (int b = 0; b < 4; b++) begin
        int sel, k, d, ph_idx;
        bit val, rest, base, inv, req, into;
        sel = 3 * lv(bank_ctrl[4*b+2 +: 2]) + lv(bank_ctrl[4*b +: 2]);
        inv = 0;
        k = sel - 4;
        if (b >= 2) k = 2 * k;
        d = ((k % p) + p) % p;
        ph_idx = (m_cnt - d + p) % p;
        base = (ph_idx < p / 2);
        if (!pos_edge) base = !base;
        val = base;
        if (b >= 2 && sel == 0) val = (m_pc % 2 == 0);
        else if (b == 2 && sel == 8) val = (m_pc / 2 == 0);
        else if (b == 3 && sel == 8) begin
          inv = 1;
          val = (pos_edge ? (m_cnt >= p / 2) : (m_cnt < p / 2));
        end
        rest = inv ? pos_edge : !pos_edge;
        req = m_stop && (tmid ? (sel == 0) : (b != 1));
        into = (val == rest) && (m_raw[b] != rest);
        if (into) m_stp[b] = req;
        m_out[b] = m_stp[b] ? rest : val;
        m_raw[b] = val;
      end
      if (m_cnt >= p - 1) begin
        m_cnt = 0; m_pc = (m_pc + 1) % 4;
      end else m_cnt++;
      m_stop = stop_en;
    end
  end

  // compares all eight outputs; both outputs of a pair against one value (R10)
  task automatic check();
    logic [3:0] exp;
    for (int b = 0; b < 4; b++) exp[b] = m_out[b];
    vectors++;
    if (out_a !== exp || out_b !== exp) begin
      miscompares++;
      $display("FAIL %s cycle %0d: out_a=%b out_b=%b expected %b", tag, cyc, out_a, out_b, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      check();
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run exceeded %0d cycles", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0] fl[3];
    fl[0] = 2'b00; fl[1] = 2'b10; fl[2] = 2'b01;
    rst = 1; freq_sel = 2'b01; pos_edge = 1; stop_en = 0; test_sel = 2'b00;
    bank_ctrl = {4{word(4)}};
    tag = "R11"; step(3);
    rst = 0; tag = "R1"; step(40);

    // mode sweep over all frequencies, both polarities
    for (int fi = 0; fi < 3; fi++) begin
      rst = 1; freq_sel = fl[fi]; tag = "R11"; step(2);
      rst = 0;
      for (int pe = 1; pe >= 0; pe--) begin
        pos_edge = pe[0];
        for (int sel = 0; sel < 9; sel++) begin
          bank_ctrl = {4{word(sel)}};
          tag = pe[0] ? "R2 R3 R4 R1" : "R6";
          step(4 * per_of(freq_sel) + 4);
        end
      end
    end

    // open code acts as MID (R5)
    rst = 1; freq_sel = 2'b01; pos_edge = 1; tag = "R11"; step(2);
    rst = 0; tag = "R5";
    bank_ctrl = {4{4'b1111}};           step(36);
    bank_ctrl = {4{4'b1100}};           step(36);
    bank_ctrl = {4{4'b0011}};           step(36);
    bank_ctrl = {4{4'b1011}};           step(36);

    // synchronous stop, rest levels, feedback bank exemption
    for (int v = 0; v < 2; v++) begin
      for (int pe = 1; pe >= 0; pe--) begin
        pos_edge = pe[0];
        bank_ctrl = {(v == 0) ? word(8) : word(1), word(8), word(2), word(5)};
        tag = "R6"; step(30);
        stop_en = 1; tag = "R7 R8"; step(90);
        stop_en = 0; tag = "R8"; step(100);
      end
    end

    // test MID: only LL banks disabled, bank 2 included (R9)
    pos_edge = 1; test_sel = 2'b01;
    bank_ctrl = {word(2), word(4), word(0), word(0)};
    tag = "R9"; step(30);
    stop_en = 1; step(90);
    stop_en = 0; step(100);
    bank_ctrl = {word(8), word(0), word(6), word(3)};
    stop_en = 1; step(90);
    stop_en = 0; step(100);
    test_sel = 2'b00;

    // reset in the middle of a stopped run (R11)
    bank_ctrl = {4{word(4)}};
    stop_en = 1; tag = "R7"; step(40);
    rst = 1; tag = "R11"; step(3);
    rst = 0; stop_en = 0; step(40);

    summary();
    $finish;
  end

endmodule